// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the arithmetic-logic unit of a small integer datapath, bundled with the decoder that chooses its operation. A controller supplies a 2-bit operation class. One class value forces an addition, which is used for address arithmetic and for stepping the program counter. Another forces a subtraction, which is used for equality compares. A third passes control to the 6-bit function field of a register-register instruction. The decoder maps these inputs to a 3-bit operation select. The ALU applies that select to two 32-bit operands.

The ALU offers five operations: bitwise AND, bitwise OR, add, subtract and signed set-on-less-than. Beside the result it reports a zero flag and a signed overflow flag. The decoder also raises an illegal-function flag when the function field holds a code it does not recognise. Both parts are purely combinational, so every output follows the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: Class 2'b00 and class 2'b11 select add (op_sel 3'b010) and class 2'b01 selects subtract (op_sel 3'b110). In these three classes the function field has no effect and bad_func stays 0.
- R2: Under class 2'b10 the function field picks the operation: 6'h20 selects add (3'b010), 6'h22 selects subtract (3'b110), 6'h24 selects AND (3'b000), 6'h25 selects OR (3'b001) and 6'h2A selects set-on-less-than (3'b111). For these codes bad_func is 0.
- R3: Under class 2'b10, any other function code selects add (3'b010) and drives bad_func to 1.
- R4: AND and OR produce the bitwise AND and the bitwise OR of the two operands.
- R5: Add and subtract produce a + b and a - b, both modulo 2^32.
- R6: Set-on-less-than gives 32'h1 when a is less than b as signed two's-complement values, and 32'h0 otherwise. The answer stays correct when a - b overflows.
- R7: zero_flag is 1 exactly when every bit of result is 0.
- R8: On add, ovf_flag is 1 when both operands have the same sign and the sign of the result differs from the sign of a.
- R9: On subtract, ovf_flag is 1 when the operands have different signs and the sign of the result differs from the sign of a.
- R10: ovf_flag is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the controller |
| func_code | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | output | 3 | Decoded operation select |
| result | output | 32 | ALU result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow on add or subtract |
| bad_func | output | 1 | Unrecognised function code under class 2'b10 |

## Verification
The block holds no state, so any fault in the decoder or the datapath shows at the ports in the same cycle as the input that triggers it. A wrong decode shows directly on op_sel and bad_func. It also shows as a result with the wrong sign or the wrong bit pattern. A sign slip in the overflow or set-on-less-than logic only shows with operands near the signed limits. The vectors therefore concentrate on 32'h8000_0000, 32'h7FFF_FFFF and all-ones operands, and two sweeps cover all 64 function codes under a forced class and under the function-field class.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_RSVD = 2'b11
  } op_class_e;

  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [1:0]        op_class,
  input  logic [FUNC_W-1:0] func_code,
  output alu_sel_e          sel,
  output logic              illegal
);

  alu_sel_e sel_func;
  logic     func_known;

  // Function-field decode, used only under the function class
  always_comb begin
    func_known = 1'b1;
    unique case (func_code)
      FN_ADD:  sel_func = SEL_ADD;
      FN_SUB:  sel_func = SEL_SUB;
      FN_AND:  sel_func = SEL_AND;
      FN_OR:   sel_func = SEL_OR;
      FN_SLT:  sel_func = SEL_SLT;
      default: begin
        sel_func   = SEL_ADD;
        func_known = 1'b0;
      end
    endcase
  end

  always_comb begin
    illegal = 1'b0;
    unique case (op_class_e'(op_class))
      CLS_SUB:  sel = SEL_SUB;
      CLS_FUNC: begin
        sel     = sel_func;
        illegal = ~func_known;
      end
      default:  sel = SEL_ADD;
    endcase
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_v,
  output logic [WIDTH-1:0] or_v
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             less
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
  // Signed overflow: operands agree in sign, result does not
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  // True sign of a - b, valid only when sub is set
  assign less  = sum[MSB] ^ ovf;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       func_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag,
  output logic             bad_func
);

  alu_sel_e         sel;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] sum;
  logic             arith_ovf;
  logic             less;
  logic             do_sub;

  alu_op_decoder u_dec (
    .op_class  (op_class),
    .func_code (func_code),
    .sel       (sel),
    .illegal   (bad_func)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bits (
    .a     (opnd_a),
    .b     (opnd_b),
    .and_v (and_v),
    .or_v  (or_v)
  );

  assign do_sub = (sel == SEL_SUB) || (sel == SEL_SLT);

  alu_addsub #(.WIDTH(WIDTH)) u_arith (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (do_sub),
    .sum  (sum),
    .ovf  (arith_ovf),
    .less (less)
  );

  always_comb begin
    unique case (sel)
      SEL_AND: result = and_v;
      SEL_OR:  result = or_v;
      SEL_SLT: result = {{(WIDTH-1){1'b0}}, less};
      default: result = sum;
    endcase
  end

  assign op_sel    = sel;
  assign zero_flag = ~|result;
  assign ovf_flag  = arith_ovf && ((sel == SEL_ADD) || (sel == SEL_SUB));

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       op_class,
  input logic [5:0]       func_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             ovf_flag,
  input logic             bad_func
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R1
    forced_add_chk: assert (!(op_class == 2'b00) || (op_sel == 3'b010 && !bad_func))
      else $error("forced add class decoded to %b", op_sel);
    // R2
    func_add_chk: assert (!(op_class == 2'b10 && func_code == 6'h20) || (op_sel == 3'b010 && !bad_func))
      else $error("function add decoded to %b", op_sel);
    // R3
    bad_func_chk: assert (!bad_func || (op_class == 2'b10 && op_sel == 3'b010))
      else $error("illegal flag with class %b sel %b", op_class, op_sel);
    // R6
    slt_shape_chk: assert (!(op_sel == 3'b111) || (result[MSB:1] == '0))
      else $error("set-less-than upper bits not clear");
    // R7
    zero_sub_chk: assert (!(op_sel == 3'b110) || (zero_flag == (opnd_a == opnd_b)))
      else $error("zero flag disagrees with operand equality");
    // R8
    add_ovf_chk: assert (!(op_sel == 3'b010 && ovf_flag) || (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]))
      else $error("add overflow without sign condition");
    // R10
    no_overflow_chk: assert (!(op_sel == 3'b000 || op_sel == 3'b001 || op_sel == 3'b111) || !ovf_flag)
      else $error("overflow raised on non-arithmetic op %b", op_sel);
  end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class  (op_class),
  .func_code (func_code),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_sel    (op_sel),
  .result    (result),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag),
  .bad_func  (bad_func)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;

  localparam int W  = 32;
  localparam int VW = 110;
  localparam int NV = 20;

  // {class, func, a, b, result, zero, ovf, bad, sel}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {2'b00, 6'h2A, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0, 1'b0, 3'b010}, // R1
    {2'b01, 6'h20, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 3'b110}, // R1 R7
    {2'b11, 6'h22, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 3'b010}, // R1
    {2'b10, 6'h20, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 3'b010}, // R2 R5 R7
    {2'b10, 6'h22, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 3'b110}, // R5
    {2'b10, 6'h24, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0, 1'b0, 1'b0, 3'b000}, // R4
    {2'b10, 6'h25, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 1'b0, 1'b0, 1'b0, 3'b001}, // R4
    {2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 3'b111}, // R6
    {2'b10, 6'h2A, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 3'b111}, // R6 R7
    {2'b10, 6'h2A, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 3'b111}, // R6 R10
    {2'b10, 6'h2A, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 3'b111}, // R6 R10
    {2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 3'b010}, // R8
    {2'b00, 6'h00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 3'b010}, // R8 R7
    {2'b10, 6'h22, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 3'b110}, // R9
    {2'b01, 6'h3F, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 3'b110}, // R9
    {2'b10, 6'h3F, 32'h0000_0002, 32'h0000_0003, 32'h0000_0005, 1'b0, 1'b0, 1'b1, 3'b010}, // R3
    {2'b10, 6'h00, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 3'b010}, // R3 R8
    {2'b10, 6'h24, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'b000}, // R10
    {2'b10, 6'h22, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 3'b110}, // R9
    {2'b00, 6'h24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 3'b010}  // R8
  };

  logic         clk;
  logic         rst_n;
  logic [1:0]   op_class;
  logic [5:0]   func_code;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [2:0]   op_sel;
  logic [W-1:0] result;
  logic         zero_flag;
  logic         ovf_flag;
  logic         bad_func;

  int checks;
  int fails;
  bit finished;

  int_alu #(.WIDTH(W)) uut (
    .op_class  (op_class),
    .func_code (func_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag),
    .bad_func  (bad_func)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    op_class  = c;
    func_code = f;
    opnd_a    = a;
    opnd_b    = b;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    op_class = 2'b00;
    func_code = 6'h00;
    opnd_a = '0;
    opnd_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: idle inputs give add of zeros (R1, R7)
    check("R1_R7 idle", {result, zero_flag, ovf_flag, bad_func, op_sel},
          {32'h0, 1'b1, 1'b0, 1'b0, 3'b010});

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][109:108], VEC[i][107:102], VEC[i][101:70], VEC[i][69:38]);
      check($sformatf("vector %0d (R1..R10 table)", i),
            {result, zero_flag, ovf_flag, bad_func, op_sel}, VEC[i][37:0]);
    end

    // R1: function field has no effect under the forced classes
    for (int f = 0; f < 64; f++) begin
      apply(2'b01, 6'(f), 32'h0000_0009, 32'h0000_0004);
      check("R1 sub ignores func", {result, zero_flag, ovf_flag, bad_func, op_sel},
            {32'h0000_0005, 1'b0, 1'b0, 1'b0, 3'b110});
      apply(2'b11, 6'(f), 32'h0000_0009, 32'h0000_0004);
      check("R1 reserved ignores func", {result, zero_flag, ovf_flag, bad_func, op_sel},
            {32'h0000_000D, 1'b0, 1'b0, 1'b0, 3'b010});
    end

    // R2 / R3: full function-code sweep under class 10
    for (int f = 0; f < 64; f++) begin
      logic [2:0] es;
      logic       eb;
      eb = 1'b0;
      case (6'(f))
        6'h20:   es = 3'b010;
        6'h22:   es = 3'b110;
        6'h24:   es = 3'b000;
        6'h25:   es = 3'b001;
        6'h2A:   es = 3'b111;
        default: begin es = 3'b010; eb = 1'b1; end
      endcase
      apply(2'b10, 6'(f), 32'h0000_0006, 32'h0000_0003);
      check(eb ? "R3 illegal func" : "R2 legal func", {34'h0, bad_func, op_sel},
            {34'h0, eb, es});
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule